// File: doc/BRIEF.md
# Multiplexed Bus Word Exchanger

This block joins a narrow 12-bit port A to a wide 24-bit port B. Port B is two 12-bit halves, called the low half (bits 11:0) and the high half (bits 23:12). In the narrow-to-wide direction, each half has its own edge-triggered register. Each register loads the port A word on a rising clock edge while its active-low clock enable is asserted. Two successive narrow words can be steered into the two halves and then presented as one wide word.

In the wide-to-narrow direction, each half of port B feeds its own level-sensitive latch. A latch is transparent while its active-low latch enable is low and holds its value while that enable is high. A select input picks which latched half drives port A. No clock is involved in that path.

Both ports are tri-state at the pins. Inside the chip each port is modelled as a data-out bus plus a drive-enable bit, and each enable follows its own active-low output-enable input. Port data enters on separate data-in buses.

Top module: `mbx_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both write registers clear to zero, so `b_out` reads 24'h000000 after that edge.
- R2: When `wr_lo_en_n` is low at a rising edge of `clk`, `a_in` is stored into the low half, and `b_out[11:0]` shows it after that edge. When `wr_hi_en_n` is low, `a_in` is stored into the high half, and `b_out[23:12]` shows it.
- R3: A write register whose enable is high at a rising edge keeps its previous value.
- R4: Writing word X with only the low enable asserted, and then word Y with only the high enable asserted, leaves `b_out` equal to {Y, X}.
- R5: While `rd_lo_le_n` is low, the low latch follows `b_in[11:0]` without a clock. While `rd_hi_le_n` is low, the high latch follows `b_in[23:12]`.
- R6: While a latch enable is high, that latch holds its value, whatever `b_in` does.
- R7: `a_sel` low drives the low latch onto `a_out`. `a_sel` high drives the high latch onto `a_out`.
- R8: `a_drv` is high exactly when `a_oe_n` is low. `b_drv` is high exactly when `b_oe_n` is low. Neither output enable changes the stored data shown on `a_out` or `b_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write registers |
| rst | input | 1 | Synchronous active-high reset of the write registers |
| a_in | input | 12 | Narrow port data arriving from the pins |
| a_out | output | 12 | Narrow port data leaving to the pins |
| a_drv | output | 1 | Narrow port pin drive enable |
| b_in | input | 24 | Wide port data arriving from the pins |
| b_out | output | 24 | Wide port data leaving to the pins |
| b_drv | output | 1 | Wide port pin drive enable |
| wr_lo_en_n | input | 1 | Active-low clock enable for the low-half write register |
| wr_hi_en_n | input | 1 | Active-low clock enable for the high-half write register |
| rd_lo_le_n | input | 1 | Active-low latch enable for the low-half read latch |
| rd_hi_le_n | input | 1 | Active-low latch enable for the high-half read latch |
| a_sel | input | 1 | Read half select: 0 picks the low half, 1 the high half |
| a_oe_n | input | 1 | Active-low output enable for the narrow port |
| b_oe_n | input | 1 | Active-low output enable for the wide port |

## Verification
At every clock edge, the assertions check how each write register reacts to its enable and to reset. They also check that a transparent latch matches its input and that a closed latch stays steady between edges. Finally, they check that the select and output enables route the right latch and drive state to the pins. Other behaviour can only be shown by the bench's scenarios. These are the packing of two words written in sequence into one wide word, and latch transparency between clock edges with no clock involved. The bench also shows that a latch keeps an old value after its input has moved several times.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int HALVES = 2;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/mbx_wr_reg.sv
module mbx_wr_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!en_n) q <= d;
  end

  p_clear_r1: assert property (@(posedge clk) rst |=> q == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> q == $past(d));
  p_keep_r3: assert property (@(posedge clk) disable iff (rst)
    en_n |=> $stable(q));
endmodule

// File: rtl/mbx_rd_latch.sv
module mbx_rd_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!le_n) q <= d;
  end

  p_open_r5: assert property (@(posedge clk) disable iff (rst)
    !le_n |-> q == d);
  p_shut_r6: assert property (@(posedge clk) disable iff (rst)
    (le_n && $past(le_n)) |-> $stable(q));
endmodule

// File: rtl/mbx_port_drive.sv
module mbx_port_drive #(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mbx_pkg::half_sel_e   sel,
  input  logic [W-1:0]         lat_lo,
  input  logic [W-1:0]         lat_hi,
  input  logic                 a_oe_n,
  input  logic                 b_oe_n,
  output logic [W-1:0]         a_out,
  output logic                 a_drv,
  output logic                 b_drv
);
  always_comb begin
    unique case (sel)
      mbx_pkg::HALF_HI: a_out = lat_hi;
      default:          a_out = lat_lo;
    endcase
  end

  assign a_drv = ~a_oe_n;
  assign b_drv = ~b_oe_n;

  p_pick_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == mbx_pkg::HALF_LO) |-> a_out == lat_lo);
  p_pick_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == mbx_pkg::HALF_HI) |-> a_out == lat_hi);
endmodule

// File: rtl/mbx_exchanger.sv
module mbx_exchanger #(
  parameter int HALF_W = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [HALF_W-1:0]                 a_in,
  output logic [HALF_W-1:0]                 a_out,
  output logic                              a_drv,
  input  logic [HALF_W*mbx_pkg::HALVES-1:0] b_in,
  output logic [HALF_W*mbx_pkg::HALVES-1:0] b_out,
  output logic                              b_drv,
  input  logic                              wr_lo_en_n,
  input  logic                              wr_hi_en_n,
  input  logic                              rd_lo_le_n,
  input  logic                              rd_hi_le_n,
  input  logic                              a_sel,
  input  logic                              a_oe_n,
  input  logic                              b_oe_n
);
  localparam int N = mbx_pkg::HALVES;

  logic [N-1:0]      wr_en_n;
  logic [N-1:0]      rd_le_n;
  logic [HALF_W-1:0] lat_q [N];

  assign wr_en_n = {wr_hi_en_n, wr_lo_en_n};
  assign rd_le_n = {rd_hi_le_n, rd_lo_le_n};

  for (genvar h = 0; h < N; h++) begin : g_half
    mbx_wr_reg #(.W(HALF_W)) i_wr (
      .clk  (clk),
      .rst  (rst),
      .en_n (wr_en_n[h]),
      .d    (a_in),
      .q    (b_out[h*HALF_W +: HALF_W])
    );
    mbx_rd_latch #(.W(HALF_W)) i_rd (
      .clk  (clk),
      .rst  (rst),
      .le_n (rd_le_n[h]),
      .d    (b_in[h*HALF_W +: HALF_W]),
      .q    (lat_q[h])
    );
  end

  mbx_port_drive #(.W(HALF_W)) i_drive (
    .clk    (clk),
    .rst    (rst),
    .sel    (mbx_pkg::half_sel_e'(a_sel)),
    .lat_lo (lat_q[0]),
    .lat_hi (lat_q[1]),
    .a_oe_n (a_oe_n),
    .b_oe_n (b_oe_n),
    .a_out  (a_out),
    .a_drv  (a_drv),
    .b_drv  (b_drv)
  );

  p_drive_r8: assert property (@(posedge clk) disable iff (rst)
    (a_drv != a_oe_n) && (b_drv != b_oe_n));
endmodule

// File: tb/test_mbx_exchanger.sv
module test_mbx_exchanger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_in = '0;
  logic [11:0] a_out;
  logic        a_drv;
  logic [23:0] b_in = '0;
  logic [23:0] b_out;
  logic        b_drv;
  logic        wr_lo_en_n = 1'b1, wr_hi_en_n = 1'b1;
  logic        rd_lo_le_n = 1'b0, rd_hi_le_n = 1'b0;
  logic        a_sel = 1'b0, a_oe_n = 1'b1, b_oe_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbx_exchanger i_mbx_exchanger (.*);

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    @(negedge clk); rd_lo_le_n = 1'b1; rd_hi_le_n = 1'b1;
    wr_lo_en_n = 1'b0; wr_hi_en_n = 1'b0; a_in = 12'hFFF;
    edge_then_sample();
    chk("R1", b_out, 24'h000000);
    @(negedge clk); rst = 1'b0; wr_lo_en_n = 1'b1; wr_hi_en_n = 1'b1;
    edge_then_sample();
    chk("R1", b_out, 24'h000000);
  endtask

  task automatic t_pack();
    @(negedge clk); a_in = 12'hA5C; wr_lo_en_n = 1'b0;
    edge_then_sample();
    chk("R2", b_out, 24'h000A5C);
    @(negedge clk); a_in = 12'h3E7; wr_lo_en_n = 1'b1; wr_hi_en_n = 1'b0;
    edge_then_sample();
    chk("R4", b_out, 24'h3E7A5C);
    @(negedge clk); a_in = 12'h111; wr_hi_en_n = 1'b1; wr_lo_en_n = 1'b0;
    edge_then_sample();
    chk("R2", b_out, 24'h3E7111);
  endtask

  task automatic t_hold();
    @(negedge clk); wr_lo_en_n = 1'b1; wr_hi_en_n = 1'b1; a_in = 12'h0F0;
    edge_then_sample();
    edge_then_sample();
    chk("R3", b_out, 24'h3E7111);
  endtask

  task automatic t_latch();
    @(negedge clk); a_sel = 1'b0; a_oe_n = 1'b0; b_in = 24'h000123; rd_lo_le_n = 1'b0;
    #2 chk("R5", {12'h0, a_out}, 24'h000123);
    b_in = 24'h000456;
    #2 chk("R5", {12'h0, a_out}, 24'h000456);
    @(negedge clk); rd_lo_le_n = 1'b1;
    @(negedge clk); b_in = 24'h000789;
    #2 chk("R6", {12'h0, a_out}, 24'h000456);
    @(negedge clk); b_in = 24'h000ABC;
    #2 chk("R6", {12'h0, a_out}, 24'h000456);
  endtask

  task automatic t_select();
    @(negedge clk); b_in = 24'hBEE000; rd_hi_le_n = 1'b0;
    @(negedge clk); rd_hi_le_n = 1'b1; b_in = 24'h000000;
    @(negedge clk); a_sel = 1'b1;
    #2 chk("R7", {12'h0, a_out}, 24'h000BEE);
    @(negedge clk); a_sel = 1'b0;
    #2 chk("R7", {12'h0, a_out}, 24'h000456);
  endtask

  task automatic t_oe();
    @(negedge clk); a_oe_n = 1'b1; b_oe_n = 1'b0;
    #2 chk("R8", {22'h0, a_drv, b_drv}, 24'h000001);
    chk("R8", {12'h0, a_out}, 24'h000456);
    @(negedge clk); a_oe_n = 1'b0; b_oe_n = 1'b1;
    #2 chk("R8", {22'h0, a_drv, b_drv}, 24'h000002);
    chk("R8", b_out, 24'h3E7111);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_hold();
    t_latch();
    t_select();
    t_oe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule